// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block gives a host access to the internal 16-bit registers of a serial-link PHY through a narrow control port. The port is made of a 16-bit data-in bus, four strobes, one acknowledge line and a 16-bit data-out bus. The host issues one command at a time. A command is either a read or a write, carries a 16-bit register address and, for a write, 16-bit data. The block turns each command into a sequence of strobe handshakes on the PHY side. At the end it returns a one-cycle done pulse, an error flag and, for a read, the register value.

Each handshake has four phases. The block raises one strobe and waits for acknowledge to go high. It then drops the strobe and waits for acknowledge to go low. Each of the two waits polls the acknowledge line a bounded number of times, with a fixed gap in cycles between polls. When every poll of a wait fails, the access is abandoned with an error.

A write runs three handshakes: address capture, data capture and commit. A read runs two: address capture, then the read strobe. One write is special. A write whose data has bit 0 set puts the PHY into reset, and a PHY in reset cannot acknowledge. For that write the commit strobe is raised, the command completes at once, and the strobe is left raised.

Top module: `phy_cr_master`

## Requirements
- R1: The word for each capture step is placed on `cr_din` at least one clock before its capture strobe rises, and `cr_din` does not change on the edge that raises the strobe. The address is driven for the address and read steps, and the write data for the data and commit steps.
- R2: Each handshake raises exactly one strobe, waits for `cr_ack` high, drops the strobe, then waits for `cr_ack` low. At most one strobe is high at any time.
- R3: A write runs three handshakes in this order: `cr_cap_addr`, `cr_cap_data`, then `cr_write`. On success it ends with `done`=1 and `err`=0.
- R4: A read runs a `cr_cap_addr` handshake followed by a `cr_read` handshake. `rdata` takes the value of `cr_dout` on the edge where `cr_ack` is first seen high with `cr_read` raised, and changes at no other time.
- R5: Each wait first samples `cr_ack` one clock after it is entered. Each later sample comes `POLL_GAP`+1 clocks after the one before. A wait takes at most `MAX_POLLS` samples. When the address wait times out, `done` comes 2+(`MAX_POLLS`-1)*(`POLL_GAP`+1) clocks after the accepting edge.
- R6: When the last allowed sample of a wait fails, all four strobes go low on that same edge, and `done` and `err` are both 1 in the following cycle.
- R7: When the commit step of a write has data bit 0 set, `cr_write` rises and `done` pulses with `err`=0 on the same edge, with no wait for acknowledge. `cr_write` stays high until the next command is accepted.
- R8: `done` is high for exactly one cycle. `err` is high only together with `done`. `busy` is low whenever `done` is high.
- R9: A command is accepted only when `busy` is low, including during the cycle in which `done` is high. `cmd_valid` has no effect while `busy` is high.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request; sampled only while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timeout; valid with done |
| rdata | output | 16 | Last value read from the PHY |
| cr_din | output | 16 | Data-in bus to the PHY |
| cr_cap_addr | output | 1 | Address capture strobe |
| cr_cap_data | output | 1 | Data capture strobe |
| cr_write | output | 1 | Write commit strobe |
| cr_read | output | 1 | Read strobe |
| cr_ack | input | 1 | PHY acknowledge |
| cr_dout | input | 16 | PHY read data |

## Verification
Two things can land in the same cycle. The first is the completion pulse. The second is acceptance of the next command: the block is already idle while `done` is high. To provoke this, the bench issues a new command on exactly the cycle in which `done` is seen. The second case is a poll outcome that falls on the edge where a stray `cmd_valid` arrives during a busy access. A behavioural reference model runs on every clock. It predicts whether the new command starts on the following edge, or is dropped, and the strobes, data-in and flags are compared with that prediction each cycle. PHY register contents are also read back, so that a dropped command leaves no trace.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  // Strobe index; the order matches the control-word bit order 16..19.
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_COMMIT = 2'd2,
    PH_READ   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_HI,
    ST_WAIT_LO
  } step_e;

  function automatic phase_e next_phase(input phase_e cur, input logic is_wr);
    case (cur)
      PH_ADDR: next_phase = is_wr ? PH_DATA : PH_READ;
      PH_DATA: next_phase = PH_COMMIT;
      default: next_phase = cur;
    endcase
  endfunction

  function automatic logic is_last_phase(input phase_e p);
    is_last_phase = (p == PH_COMMIT) || (p == PH_READ);
  endfunction

  // Data bit 0 on commit resets the PHY, which then cannot acknowledge.
  function automatic logic commit_skips_ack(input logic data_lsb);
    commit_skips_ack = data_lsb;
  endfunction

endpackage

// File: rtl/phy_cr_poll.sv
module phy_cr_poll #(
  parameter int MAX_POLLS = 10,
  parameter int POLL_GAP  = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic level_ok,
  output logic poll_hit,
  output logic poll_expire
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 2);

  logic [PW-1:0] poll_cnt;
  logic [GW-1:0] gap_cnt;
  logic          poll_now;

  assign poll_now    = waiting && (gap_cnt == '0);
  assign poll_hit    = poll_now && level_ok;
  assign poll_expire = poll_now && !level_ok && (poll_cnt == PW'(MAX_POLLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt <= '0;
      gap_cnt  <= '0;
    end else if (!waiting || poll_hit || poll_expire) begin
      poll_cnt <= '0;
      gap_cnt  <= '0;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end else begin
      poll_cnt <= poll_cnt + 1'b1;
      gap_cnt  <= GW'(POLL_GAP);
    end
  end
endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
  import phy_cr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          ack,
  input  logic [DW-1:0] dout,
  input  logic          poll_hit,
  input  logic          poll_expire,
  output logic          waiting,
  output logic          level_ok,
  output logic [3:0]    stb,
  output logic [DW-1:0] din,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata
);
  step_e         step;
  phase_e        phase;
  logic          is_wr;
  logic [DW-1:0] wdata_q;

  assign waiting  = (step == ST_WAIT_HI) || (step == ST_WAIT_LO);
  assign level_ok = (step == ST_WAIT_HI) ? ack : !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= ST_IDLE;
      phase   <= PH_ADDR;
      is_wr   <= 1'b0;
      wdata_q <= '0;
      stb     <= '0;
      din     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (step)
        ST_IDLE: if (cmd_valid) begin
          is_wr   <= cmd_write;
          wdata_q <= cmd_wdata;
          din     <= cmd_addr;
          stb     <= '0;
          phase   <= PH_ADDR;
          busy    <= 1'b1;
          step    <= ST_SETUP;
        end
        ST_SETUP: begin
          stb[phase] <= 1'b1;
          if (phase == PH_COMMIT && commit_skips_ack(wdata_q[0])) begin
            done <= 1'b1;
            busy <= 1'b0;
            step <= ST_IDLE;
          end else begin
            step <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: begin
          if (poll_hit) begin
            stb <= '0;
            if (phase == PH_READ) rdata <= dout;
            step <= ST_WAIT_LO;
          end else if (poll_expire) begin
            stb  <= '0;
            done <= 1'b1;
            err  <= 1'b1;
            busy <= 1'b0;
            step <= ST_IDLE;
          end
        end
        ST_WAIT_LO: begin
          if (poll_hit) begin
            if (is_last_phase(phase)) begin
              done <= 1'b1;
              busy <= 1'b0;
              step <= ST_IDLE;
            end else begin
              phase <= next_phase(phase, is_wr);
              if (phase == PH_ADDR && is_wr) din <= wdata_q;
              step <= ST_SETUP;
            end
          end else if (poll_expire) begin
            stb  <= '0;
            done <= 1'b1;
            err  <= 1'b1;
            busy <= 1'b0;
            step <= ST_IDLE;
          end
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
  parameter int DW        = 16,
  parameter int MAX_POLLS = 10,
  parameter int POLL_GAP  = 25000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] cr_din,
  output logic          cr_cap_addr,
  output logic          cr_cap_data,
  output logic          cr_write,
  output logic          cr_read,
  input  logic          cr_ack,
  input  logic [DW-1:0] cr_dout
);
  logic       waiting;
  logic       level_ok;
  logic       poll_hit;
  logic       poll_expire;
  logic [3:0] stb;

  phy_cr_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ack(cr_ack), .dout(cr_dout),
    .poll_hit(poll_hit), .poll_expire(poll_expire),
    .waiting(waiting), .level_ok(level_ok),
    .stb(stb), .din(cr_din),
    .busy(busy), .done(done), .err(err), .rdata(rdata)
  );

  phy_cr_poll #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .waiting(waiting), .level_ok(level_ok),
    .poll_hit(poll_hit), .poll_expire(poll_expire)
  );

  assign cr_cap_addr = stb[0];
  assign cr_cap_data = stb[1];
  assign cr_write    = stb[2];
  assign cr_read     = stb[3];
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] cr_din,
  input logic          cr_cap_addr,
  input logic          cr_cap_data,
  input logic          cr_write,
  input logic          cr_read,
  input logic          poll_expire
);
  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cr_read, cr_write, cr_cap_data, cr_cap_addr}));

  // R1
  din_held_at_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cr_cap_addr) || $rose(cr_cap_data)) |-> $stable(cr_din));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expire |=> (done && err && !cr_cap_addr && !cr_cap_data && !cr_write && !cr_read));

  // R9
  start_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R4
  rdata_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(cr_read));
endmodule

bind phy_cr_master phy_cr_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .busy(busy), .done(done), .err(err), .rdata(rdata),
  .cr_din(cr_din), .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
  .cr_write(cr_write), .cr_read(cr_read), .poll_expire(poll_expire)
);

// File: tb/phy_cr_master_tb.sv
`timescale 1ns/1ps
module phy_cr_master_tb;
  localparam int DW = 16;
  localparam int MP = 10;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [DW-1:0] cmd_addr = '0, cmd_wdata = '0;
  logic busy, done, err;
  logic [DW-1:0] rdata, cr_din;
  logic cr_cap_addr, cr_cap_data, cr_write, cr_read;
  logic cr_ack = 1'b0;
  logic [DW-1:0] cr_dout = '0;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  phy_cr_master #(.DW(DW), .MAX_POLLS(MP), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .cr_din(cr_din), .cr_cap_addr(cr_cap_addr),
    .cr_cap_data(cr_cap_data), .cr_write(cr_write), .cr_read(cr_read),
    .cr_ack(cr_ack), .cr_dout(cr_dout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  logic [DW-1:0] phy_regs [16];
  logic [DW-1:0] p_addr = '0, p_data = '0;
  logic p_ca = 0, p_cd = 0, p_wr = 0;
  int phy_lat = 1, lat_cnt = 0;
  bit stuck_lo = 0, stuck_hi = 0;

  initial for (int i = 0; i < 16; i++) phy_regs[i] = '0;

  always @(negedge clk) begin
    logic tgt;
    if (rst_n) begin
      if (cr_cap_addr && !p_ca) p_addr = cr_din;
      if (cr_cap_data && !p_cd) p_data = cr_din;
      if (cr_write && !p_wr) phy_regs[p_addr[3:0]] = p_data;
      p_ca = cr_cap_addr; p_cd = cr_cap_data; p_wr = cr_write;
      tgt = (cr_cap_addr | cr_cap_data | cr_write | cr_read) && !(cr_write && p_data[0]);
      if (stuck_lo) tgt = 1'b0;
      if (stuck_hi && cr_ack) tgt = 1'b1;
      if (cr_ack != tgt) begin
        lat_cnt++;
        if (lat_cnt >= phy_lat) begin cr_ack = tgt; lat_cnt = 0; end
      end else lat_cnt = 0;
      cr_dout = cr_read ? phy_regs[p_addr[3:0]] : 16'h0;
    end
  end

  // ---------------- reference model ----------------
  logic [3:0] e_stb = '0;
  logic [DW-1:0] e_din = '0, e_rdata = '0;
  logic e_busy = 0, e_done = 0, e_err = 0;

  task automatic m_wait(input logic lvl, output bit ok);
    ok = 0;
    for (int p = 0; p < MP; p++) begin
      @(posedge clk);
      if (cr_ack === lvl) begin ok = 1; return; end
      if (p != MP - 1) repeat (GAP) @(posedge clk);
    end
  endtask

  task automatic m_abort();
    e_stb = '0; e_done = 1; e_err = 1; e_busy = 0;
  endtask

  task automatic m_hs(input int k, output bit ok);
    @(posedge clk);
    e_stb[k] = 1'b1;
    m_wait(1'b1, ok);
    if (!ok) begin m_abort(); return; end
    e_stb = '0;
    if (k == 3) e_rdata = cr_dout;
    m_wait(1'b0, ok);
    if (!ok) m_abort();
  endtask

  task automatic m_run();
    bit ok;
    logic wr;
    logic [DW-1:0] d;
    wr = cmd_write; d = cmd_wdata;
    e_din = cmd_addr; e_stb = '0; e_busy = 1;
    m_hs(0, ok);
    if (!ok) return;
    if (wr) begin
      e_din = d;
      m_hs(1, ok);
      if (!ok) return;
      if (d[0]) begin
        @(posedge clk);
        e_stb[2] = 1'b1; e_done = 1; e_busy = 0;
        return;
      end
      m_hs(2, ok);
      if (!ok) return;
    end else begin
      m_hs(3, ok);
      if (!ok) return;
    end
    e_done = 1; e_busy = 0;
  endtask

  initial forever begin
    @(posedge clk);
    if (!rst_n) begin
      e_stb = '0; e_din = '0; e_rdata = '0; e_busy = 0; e_done = 0; e_err = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (cmd_valid) m_run();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(e_stb == {cr_read, cr_write, cr_cap_data, cr_cap_addr}, "R2", "strobes",
        {cr_read, cr_write, cr_cap_data, cr_cap_addr}, e_stb);
    chk(e_din == cr_din, "R1", "cr_din", cr_din, e_din);
    chk(e_busy == busy, "R9", "busy", busy, e_busy);
    chk(e_done == done, "R8", "done", done, e_done);
    chk(e_err == err, "R6", "err", err, e_err);
    chk(e_rdata == rdata, "R4", "rdata", rdata, e_rdata);
  end

  // ---------------- stimulus ----------------
  task automatic do_cmd(input logic wr, input logic [DW-1:0] a, input logic [DW-1:0] d,
                        output logic err_o, output int cyc);
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done) begin @(negedge clk); cyc++; end
    err_o = err;
  endtask

  initial begin
    logic e;
    int c;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, err, cr_cap_addr, cr_cap_data, cr_write, cr_read} == 7'b0 &&
        rdata == '0 && cr_din == '0, "R10", "outputs in reset",
        {busy, done, err, cr_cap_addr, cr_cap_data, cr_write, cr_read}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 write, fast PHY
    do_cmd(1, 16'h0003, 16'h1234, e, c);
    chk(e == 0, "R3", "write err", e, 0);
    chk(phy_regs[3] == 16'h1234, "R3", "PHY reg 3", phy_regs[3], 16'h1234);
    // R9 back-to-back: next command issued in the done cycle
    do_cmd(0, 16'h0003, 16'h0000, e, c);
    chk(e == 0 && rdata == 16'h1234, "R4", "read back", rdata, 16'h1234);
    @(negedge clk);
    chk(done == 0, "R8", "done width", done, 0);

    // R5 slow PHY needs several polls
    phy_lat = 6;
    do_cmd(1, 16'h0005, 16'hABCE, e, c);
    chk(e == 0 && phy_regs[5] == 16'hABCE, "R5", "slow write", phy_regs[5], 16'hABCE);
    @(negedge clk);
    do_cmd(0, 16'h0005, 16'h0000, e, c);
    chk(rdata == 16'hABCE, "R5", "slow read", rdata, 16'hABCE);
    phy_lat = 1;

    // R5/R6 timeout with ack stuck low
    @(negedge clk);
    stuck_lo = 1;
    do_cmd(1, 16'h0006, 16'h0F0E, e, c);
    chk(e == 1, "R6", "timeout err", e, 1);
    chk(c == 2 + (MP - 1) * (GAP + 1), "R5", "timeout latency", c, 2 + (MP - 1) * (GAP + 1));
    chk({cr_cap_addr, cr_cap_data, cr_write, cr_read} == 0, "R6", "strobes after timeout",
        {cr_cap_addr, cr_cap_data, cr_write, cr_read}, 0);
    stuck_lo = 0;

    // R6 ack stuck high: drop wait times out
    @(negedge clk);
    stuck_hi = 1;
    do_cmd(0, 16'h0003, 16'h0000, e, c);
    chk(e == 1, "R6", "stuck-high err", e, 1);
    stuck_hi = 0;
    repeat (4) @(negedge clk);

    // R7 reset write skips the commit acknowledge
    do_cmd(1, 16'h0007, 16'h0001, e, c);
    chk(e == 0, "R7", "reset write err", e, 0);
    repeat (3) @(negedge clk);
    chk(cr_write == 1 && busy == 0, "R7", "write strobe held", cr_write, 1);
    do_cmd(0, 16'h0007, 16'h0000, e, c);
    chk(cr_write == 0 && rdata == 16'h0001, "R7", "strobe cleared, reg read", rdata, 16'h0001);

    // R9 stray command while busy is ignored
    @(negedge clk);
    phy_lat = 3;
    cmd_write = 0; cmd_addr = 16'h0003; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    repeat (5) @(negedge clk);
    cmd_write = 1; cmd_addr = 16'h0009; cmd_wdata = 16'h5555; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    while (!done) @(negedge clk);
    chk(rdata == 16'h1234, "R4", "read under stray cmd", rdata, 16'h1234);
    repeat (6) @(negedge clk);
    chk(busy == 0 && phy_regs[9] == 16'h0000, "R9", "stray write dropped", phy_regs[9], 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule